// File: doc/BRIEF.md
# Ratio-Coded Audio Clock Divider

This block derives two audio clocks, a bit clock and a master clock, from source-clock ticks. Each clock is programmed with a 32-bit ratio code rather than a plain divide count. The integer divide ratio is N = floor(2^32 / code). When software computes the code from a target frequency, the low 12 bits of the code come out zero. The block works out N itself with a sequential reciprocal divider whenever a code is written. It then produces a divided clock with close to even duty, and a one-cycle strobe at the start of every output period.

Both clocks run inside a single system-clock domain and advance only on tick inputs. One tick input stands for a fixed peripheral clock and the other for an audio PLL clock. A select input per channel picks which tick stream that channel counts. The master clock has its own enable, and it also stays off whenever its last code was zero. A new code never cuts an output period short: the new ratio is taken up at the next period boundary.

Top module: `ratio_clk_divider`

## Requirements
- R1: While reset is low and after its release, `bit_clk`, `bit_stb`, `mst_clk` and `mst_stb` are 0.
- R2: For a code S of at least 8192, each output period lasts N = floor(2^32 / S) ticks of the selected source.
- R3: Within each period the divided clock is high for floor(N/2) ticks, then low for the remaining N - floor(N/2) ticks.
- R4: A code below 8192, including zero on the bit clock, gives divide-by-2.
- R5: After reset, a clock stays low until its first ratio has been computed (about 34 system cycles after the write). It then starts on a tick.
- R6: A code written in the middle of a period does not change that period. The new ratio applies from the next period boundary.
- R7: The divided clock changes level only on a tick of its selected source. Select 0 picks `tick_fixed` and select 1 picks `tick_pll`, chosen separately for each channel.
- R8: Each strobe output is high for exactly one system cycle per period, in the cycle where the divided clock rises.
- R9: The master clock runs only while `mst_enable` is 1 and its last computed code was nonzero. When either condition is lost, it stops low at the next period boundary.
- R10: A code written while the previous one is still being divided restarts the computation. Only the latest code takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fixed | input | 1 | Tick of the fixed peripheral source |
| tick_pll | input | 1 | Tick of the audio PLL source |
| bit_code | input | 32 | Ratio code for the bit clock |
| bit_code_wr | input | 1 | Write strobe for `bit_code` |
| bit_src_sel | input | 1 | Bit clock source: 0 fixed, 1 PLL |
| mst_code | input | 32 | Ratio code for the master clock |
| mst_code_wr | input | 1 | Write strobe for `mst_code` |
| mst_src_sel | input | 1 | Master clock source: 0 fixed, 1 PLL |
| mst_enable | input | 1 | Master clock enable |
| bit_clk | output | 1 | Divided bit clock |
| bit_stb | output | 1 | Bit clock period-start strobe |
| mst_clk | output | 1 | Divided master clock |
| mst_stb | output | 1 | Master clock period-start strobe |

## Verification
The assertions assume that the tick inputs and the select inputs are synchronous to `clk`. They also assume that reset is held low across at least one clock edge, so every `$past` term starts from reset values. The quotient check assumes the code does not change while a write strobe is low, because the divider samples the code only on the strobe. The stimulus drives all inputs at falling edges. Write strobes last one cycle, the PLL tick is a regular one-in-three pattern, and no code is written that would make a period longer than a few hundred ticks.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_t;

  typedef enum logic {
    SRC_FIXED = 1'b0,
    SRC_PLL   = 1'b1
  } src_sel_t;

  // Smallest divide ratio the generator can produce.
  localparam int unsigned RATIO_FLOOR = 2;

  // Code below which the ratio is clamped to RATIO_FLOOR.
  function automatic logic [63:0] clamp_code(input int unsigned zero_lsbs);
    return 64'(RATIO_FLOOR) << zero_lsbs;
  endfunction

endpackage

// File: rtl/recip_div.sv
module recip_div
  import clkdiv_pkg::*;
#(
  parameter int SET_W     = 32,
  parameter int ZERO_LSBS = 12,
  parameter int RAT_W     = SET_W - ZERO_LSBS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] code,
  output logic             done,
  output logic [RAT_W-1:0] ratio,
  output logic             code_zero
);

  localparam int DVD_W = SET_W + 1;
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [SET_W:0] MIN_CODE = (SET_W + 1)'(clamp_code(ZERO_LSBS));

  div_state_t       state;
  logic [SET_W:0]   rem;
  logic [DVD_W-1:0] dvd;
  logic [DVD_W-1:0] quo;
  logic [SET_W-1:0] divisor;
  logic [CNT_W-1:0] iter;
  logic             small_q;
  logic             zero_q;
  logic             done_q;

  // One restoring step: shift in the next dividend bit, try to subtract.
  logic [SET_W:0] rem_sh;
  logic           fits;
  logic [SET_W:0] rem_nx;

  always_comb begin
    rem_sh = {rem[SET_W-1:0], dvd[DVD_W-1]};
    fits   = rem_sh >= {1'b0, divisor};
    rem_nx = fits ? (rem_sh - {1'b0, divisor}) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= DIV_IDLE;
      rem     <= '0;
      dvd     <= '0;
      quo     <= '0;
      divisor <= '0;
      iter    <= '0;
      small_q <= 1'b1;
      zero_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state   <= DIV_RUN;
        divisor <= code;
        small_q <= {1'b0, code} < MIN_CODE;
        zero_q  <= code == '0;
        rem     <= '0;
        dvd     <= {1'b1, {SET_W{1'b0}}};
        quo     <= '0;
        iter    <= CNT_W'(DVD_W);
      end else if (state == DIV_RUN) begin
        rem  <= rem_nx;
        dvd  <= {dvd[DVD_W-2:0], 1'b0};
        quo  <= {quo[DVD_W-2:0], fits};
        iter <= iter - 1'b1;
        if (iter == CNT_W'(1)) begin
          state  <= DIV_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done      = done_q;
  assign ratio     = small_q ? RAT_W'(RATIO_FLOOR) : quo[RAT_W-1:0];
  assign code_zero = zero_q;

  AST_QUOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !small_q) |->
      ((64'(quo) * 64'(divisor)) <= (64'(1) << SET_W)) &&
      (((64'(quo) + 64'(1)) * 64'(divisor)) > (64'(1) << SET_W))); // R2

  AST_RATIO_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ratio >= RAT_W'(RATIO_FLOOR))); // R4

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == DIV_IDLE && !start) |=> $stable(ratio)); // R10

endmodule

// File: rtl/ratio_gen.sv
module ratio_gen #(
  parameter int RAT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic             load,
  input  logic [RAT_W-1:0] load_ratio,
  output logic             clk_out,
  output logic             stb_out
);

  function automatic logic [RAT_W-1:0] high_ticks(input logic [RAT_W-1:0] n);
    return n >> 1;
  endfunction

  logic [RAT_W-1:0] cur_n;
  logic [RAT_W-1:0] pend_n;
  logic             pend_v;
  logic             have_n;
  logic             running;
  logic [RAT_W-1:0] cnt;
  logic             out_q;
  logic             stb_q;

  logic             at_end;
  logic [RAT_W-1:0] cnt_inc;

  assign at_end  = !running || (cnt == cur_n - RAT_W'(1));
  assign cnt_inc = cnt + RAT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_n   <= RAT_W'(2);
      pend_n  <= RAT_W'(2);
      pend_v  <= 1'b0;
      have_n  <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
      out_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (tick) begin
        if (at_end) begin
          if (pend_v) begin
            cur_n  <= pend_n;
            have_n <= 1'b1;
            pend_v <= 1'b0;
          end
          cnt <= '0;
          if (run_en && (pend_v || have_n)) begin
            running <= 1'b1;
            out_q   <= 1'b1;
            stb_q   <= 1'b1;
          end else begin
            running <= 1'b0;
            out_q   <= 1'b0;
          end
        end else begin
          cnt   <= cnt_inc;
          out_q <= cnt_inc < high_ticks(cur_n);
        end
      end
      if (load) begin
        pend_n <= load_ratio;
        pend_v <= 1'b1;
      end
    end
  end

  assign clk_out = out_q;
  assign stb_out = stb_q;

  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> $past(tick)); // R7

  AST_SWAP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_n != $past(cur_n)) |->
      ($past(tick) && (!$past(running) || ($past(cnt) == $past(cur_n) - RAT_W'(1))))); // R6

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < cur_n)); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !out_q); // R5

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R8

  AST_RISE_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> stb_q); // R8

endmodule

// File: rtl/clk_chan.sv
module clk_chan
  import clkdiv_pkg::*;
#(
  parameter int SET_W     = 32,
  parameter int ZERO_LSBS = 12,
  parameter bit GATE_ZERO = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             src_sel,
  input  logic [SET_W-1:0] code,
  input  logic             code_wr,
  input  logic             enable,
  output logic             clk_out,
  output logic             stb_out
);

  localparam int   RAT_W       = SET_W - ZERO_LSBS;
  localparam logic IGNORE_ZERO = !GATE_ZERO;

  logic             tick;
  logic             div_done;
  logic [RAT_W-1:0] div_ratio;
  logic             div_zero;
  logic             nz_q;
  logic             en_eff;

  assign tick = (src_sel_t'(src_sel) == SRC_PLL) ? tick_b : tick_a;

  recip_div #(
    .SET_W    (SET_W),
    .ZERO_LSBS(ZERO_LSBS),
    .RAT_W    (RAT_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (code_wr),
    .code     (code),
    .done     (div_done),
    .ratio    (div_ratio),
    .code_zero(div_zero)
  );

  // The zero flag moves with its ratio, so gating and rate change together.
  always_ff @(posedge clk) begin
    if (!rst_n) nz_q <= 1'b0;
    else if (div_done) nz_q <= !div_zero;
  end

  assign en_eff = enable && (nz_q || IGNORE_ZERO);

  ratio_gen #(
    .RAT_W(RAT_W)
  ) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run_en    (en_eff),
    .load      (div_done),
    .load_ratio(div_ratio),
    .clk_out   (clk_out),
    .stb_out   (stb_out)
  );

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(en_eff)); // R9

endmodule

// File: rtl/ratio_clk_divider.sv
module ratio_clk_divider #(
  parameter int SET_W     = 32,
  parameter int ZERO_LSBS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_fixed,
  input  logic             tick_pll,
  input  logic [SET_W-1:0] bit_code,
  input  logic             bit_code_wr,
  input  logic             bit_src_sel,
  input  logic [SET_W-1:0] mst_code,
  input  logic             mst_code_wr,
  input  logic             mst_src_sel,
  input  logic             mst_enable,
  output logic             bit_clk,
  output logic             bit_stb,
  output logic             mst_clk,
  output logic             mst_stb
);

  clk_chan #(
    .SET_W    (SET_W),
    .ZERO_LSBS(ZERO_LSBS),
    .GATE_ZERO(1'b0)
  ) u_bit (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_a (tick_fixed),
    .tick_b (tick_pll),
    .src_sel(bit_src_sel),
    .code   (bit_code),
    .code_wr(bit_code_wr),
    .enable (1'b1),
    .clk_out(bit_clk),
    .stb_out(bit_stb)
  );

  clk_chan #(
    .SET_W    (SET_W),
    .ZERO_LSBS(ZERO_LSBS),
    .GATE_ZERO(1'b1)
  ) u_mst (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_a (tick_fixed),
    .tick_b (tick_pll),
    .src_sel(mst_src_sel),
    .code   (mst_code),
    .code_wr(mst_code_wr),
    .enable (mst_enable),
    .clk_out(mst_clk),
    .stb_out(mst_stb)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!bit_clk && !bit_stb && !mst_clk && !mst_stb)); // R1

endmodule

// File: tb/tb_ratio_clk_divider.sv
`timescale 1ns/1ps
module tb_ratio_clk_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fixed = 1'b1;
  logic        tick_pll = 1'b0;
  logic [31:0] bit_code = '0;
  logic        bit_code_wr = 1'b0;
  logic        bit_src_sel = 1'b0;
  logic [31:0] mst_code = '0;
  logic        mst_code_wr = 1'b0;
  logic        mst_src_sel = 1'b0;
  logic        mst_enable = 1'b0;
  logic        bit_clk, bit_stb, mst_clk, mst_stb;

  int checks = 0;
  int failures = 0;

  ratio_clk_divider dut (
    .clk(clk), .rst_n(rst_n), .tick_fixed(tick_fixed), .tick_pll(tick_pll),
    .bit_code(bit_code), .bit_code_wr(bit_code_wr), .bit_src_sel(bit_src_sel),
    .mst_code(mst_code), .mst_code_wr(mst_code_wr), .mst_src_sel(mst_src_sel),
    .mst_enable(mst_enable), .bit_clk(bit_clk), .bit_stb(bit_stb),
    .mst_clk(mst_clk), .mst_stb(mst_stb)
  );

  always #2.5 clk = ~clk;

  // PLL tick: one system cycle in three.
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 3;
      tick_pll = (ph == 0);
    end
  end

  initial begin
    #(180000 * 5);
    failures++;
    $display("FAIL watchdog: run did not complete (actual=timeout expected=done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // {code, expected ratio}, expected = floor(2^32 / code), clamped to 2.
  localparam logic [63:0] VEC [9] = '{
    {32'h8000_0000, 32'd2},
    {32'h5555_5000, 32'd3},
    {32'h4000_0000, 32'd4},
    {32'h3333_3000, 32'd5},
    {32'h1C71_C000, 32'd9},
    {32'h0AAA_A000, 32'd24},
    {32'h00FF_F000, 32'd256},
    {32'h0000_1000, 32'd2},
    {32'h0000_0000, 32'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int which);
    return (which == 0) ? bit_clk : mst_clk;
  endfunction

  function automatic logic stb(input int which);
    return (which == 0) ? bit_stb : mst_stb;
  endfunction

  task automatic wr_bit(input logic [31:0] v);
    @(negedge clk); bit_code = v; bit_code_wr = 1'b1;
    @(negedge clk); bit_code_wr = 1'b0;
  endtask

  task automatic wr_mst(input logic [31:0] v);
    @(negedge clk); mst_code = v; mst_code_wr = 1'b1;
    @(negedge clk); mst_code_wr = 1'b0;
  endtask

  task automatic wait_rise(input int which, input int limit, output bit found);
    logic p;
    p = sig(which);
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sig(which) && !p) begin found = 1'b1; return; end
      p = sig(which);
    end
  endtask

  task automatic measure(input int which, output int per, output int hi,
                         output int stbs, output bit ok);
    logic p;
    per = 0; hi = 0; stbs = 0;
    wait_rise(which, 3000, ok);
    if (!ok) return;
    per = 1; hi = 1; stbs = int'(stb(which));
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      p = sig(which);
      @(negedge clk);
      if (sig(which) && !p) begin ok = 1'b1; return; end
      per++;
      hi += int'(sig(which));
      stbs += int'(stb(which));
    end
  endtask

  task automatic count_high(input int which, input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      highs += int'(sig(which));
    end
  endtask

  initial begin
    int per, hi, stbs, highs, n;
    bit ok;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!bit_clk && !bit_stb && !mst_clk && !mst_stb, "R1 outputs low in reset", int'(bit_clk), 0);
    @(negedge clk); rst_n = 1'b1;
    count_high(0, 20, highs);
    check(highs == 0 && !bit_stb && !mst_stb, "R1 outputs low after reset release", highs, 0);

    // R5: nothing before the first ratio is ready
    wr_bit(VEC[0][63:32]);
    count_high(0, 30, highs);
    check(highs == 0, "R5 low while ratio is computed", highs, 0);

    // Table walk: R2 period, R3 duty, R8 strobe, R4 clamp rows
    foreach (VEC[k]) begin
      n = int'(VEC[k][31:0]);
      if (k != 0) wr_bit(VEC[k][63:32]);
      repeat (40) @(negedge clk);
      measure(0, per, hi, stbs, ok);
      check(ok && per == n, (n == 2 && k >= 7) ? "R4 small code period" : "R2 period", per, n);
      check(ok && hi == n / 2, "R3 high ticks", hi, n / 2);
      check(ok && stbs == 1, "R8 one strobe per period", stbs, 1);
    end

    // R6: mid-period write keeps the running period
    wr_bit(32'h00FF_F000);
    repeat (40) @(negedge clk);
    wait_rise(0, 3000, ok);
    per = 1;
    for (int i = 0; i < 600; i++) begin
      logic p;
      p = bit_clk;
      if (i == 4) begin bit_code = 32'h4000_0000; bit_code_wr = 1'b1; end
      if (i == 5) bit_code_wr = 1'b0;
      @(negedge clk);
      if (bit_clk && !p) break;
      per++;
    end
    check(per == 256, "R6 running period completes with old ratio", per, 256);
    measure(0, per, hi, stbs, ok);
    check(ok && per == 4, "R6 new ratio from next boundary", per, 4);

    // R10: second write during division wins
    wr_bit(32'h3333_3000);
    @(negedge clk);
    wr_bit(32'h1C71_C000);
    repeat (45) @(negedge clk);
    measure(0, per, hi, stbs, ok);
    check(ok && per == 9, "R10 latest code wins", per, 9);
    measure(0, per, hi, stbs, ok);
    check(ok && per == 9, "R10 no stale ratio", per, 9);

    // R7: PLL source, tick one cycle in three
    @(negedge clk); bit_src_sel = 1'b1;
    wr_bit(32'h4000_0000);
    repeat (60) @(negedge clk);
    measure(0, per, hi, stbs, ok);
    check(ok && per == 12, "R7 period on PLL ticks", per, 12);
    check(ok && hi == 6, "R7 high time on PLL ticks", hi, 6);
    check(ok && stbs == 1, "R8 one strobe on PLL source", stbs, 1);

    // R9: master clock gating
    wr_mst(32'h4000_0000);
    count_high(1, 100, highs);
    check(highs == 0, "R9 master off while disabled", highs, 0);
    @(negedge clk); mst_enable = 1'b1;
    measure(1, per, hi, stbs, ok);
    check(ok && per == 4 && hi == 2, "R9 master runs when enabled", per, 4);
    wr_mst(32'h0000_0000);
    repeat (60) @(negedge clk);
    count_high(1, 50, highs);
    check(highs == 0, "R9 master off after zero code", highs, 0);
    wr_mst(32'h2000_0000);
    repeat (40) @(negedge clk);
    measure(1, per, hi, stbs, ok);
    check(ok && per == 8 && hi == 4, "R9 master resumes on nonzero code", per, 8);
    @(negedge clk); mst_enable = 1'b0;
    repeat (10) @(negedge clk);
    count_high(1, 50, highs);
    check(highs == 0 && !mst_clk, "R9 master stops low after disable", highs, 0);
    // master on PLL source via its own select
    @(negedge clk); mst_src_sel = 1'b1; mst_enable = 1'b1;
    measure(1, per, hi, stbs, ok);
    check(ok && per == 24, "R7 master select picks PLL ticks", per, 24);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule